// File: doc/BRIEF.md
# Hint-Based Clock Gate Controller

This block computes the enable for every gated clock in a subsystem. Clocks fall into two groups. Peripheral clocks follow one software enable bit each. Transactional-unit clocks follow a software hint bit together with an idle indication from the unit they feed. The result is that software can ask for a unit's clock to stop, but the clock keeps running until that unit has finished its work. A global clock enable from the power manager can stop every clock. A multi-bit scan-mode input can force every clock on. Each enable output drives an external clock-gate cell.

Software reaches the block through a plain single-cycle register port. A write is one cycle with `reg_wr_en` high. A read is combinational on `reg_addr`. Nothing streams through the block, so there is no valid/ready handshake and the port never applies back-pressure. The hint-status register shows the real state of each transactional gate, one cycle late. It does not echo the hint that was written. A one-bit jitter register drives a pin of its own.

Top module: `cg_hint_gate_ctrl`

## Requirements
- R1: After reset, all peripheral enable bits and all hint bits are 1, all hint-status bits are 1, and the jitter register is 0.
- R2: When scan mode is inactive, peripheral clock enable i is high exactly when peripheral bit i (address 0, bit i) and the global enable are both 1. A write takes effect on the output in the cycle after the write edge.
- R3: Scan mode is active only when `scan_mode` equals 4'hA. While it is active, every peripheral and transactional enable is 1 whatever the other inputs are. Any other `scan_mode` value has no effect.
- R4: With the global enable at 1, transactional enable i is 1 whenever hint bit i (address 1, bit i) is 1.
- R5: Each `unit_idle` bit passes through a two-flop synchronizer. A unit whose hint is 0 has its enable drop after the second clock edge that samples its idle bit high.
- R6: With the global enable at 1, a unit whose synchronized idle bit is 0 (busy) keeps its enable at 1 even when its hint is 0.
- R7: When scan mode is inactive and the global enable is 0, every peripheral and transactional enable is 0.
- R8: Hint-status bit i (address 2, bit i) holds transactional enable i as it was one cycle earlier. For idle units with the global enable at 1, it therefore settles to the hint bit. All-ones hints give all-ones status.
- R9: A write to the hint-status address (2) changes no register.
- R10: Bit 0 at address 3 is the jitter register, and it drives `jitter_en` directly.
- R11: `reg_rdata` returns the register selected by `reg_addr` (0 peripheral enables, 1 hints, 2 hint status, 3 jitter in bit 0), zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_clk_en | input | 1 | Global clock enable from the power manager |
| scan_mode | input | 4 | Multi-bit scan indication; 4'hA means active |
| unit_idle | input | N_TRANS | Idle flag per transactional unit, asynchronous |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` |
| peri_clk_en | output | N_PERI | Enable per peripheral clock gate |
| trans_clk_en | output | N_TRANS | Enable per transactional clock gate |
| jitter_en | output | 1 | Jitter enable pin |

## Verification
The assertions assume that `unit_idle` only reaches the gate logic through the synchronizer. The idle check therefore looks exactly two cycles back at the raw input, and the bench changes idle bits only on falling clock edges so that each value is seen at a known rising edge. The assertions also assume that `scan_mode` and `glb_clk_en` are steady between falling edges. The stimulus keeps to this: it drives all inputs once per cycle, mixes the true scan pattern with other non-zero patterns, and holds the global enable mostly high so that the gating by hint and idle is exercised.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam logic [3:0] SCAN_ON = 4'hA;

  typedef enum logic [1:0] {
    ADDR_PERI = 2'd0,
    ADDR_HINT = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_JIT  = 2'd3
  } cg_addr_e;
endpackage

// File: rtl/cg_reg_bank.sv
module cg_reg_bank #(
  parameter int N_PERI  = 4,
  parameter int N_TRANS = 4,
  parameter int REG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [N_TRANS-1:0] status_in,
  output logic [REG_W-1:0]   rdata,
  output logic [N_PERI-1:0]  peri_q,
  output logic [N_TRANS-1:0] hint_q,
  output logic               jit_q
);
  import cg_pkg::*;

  cg_addr_e sel;
  assign sel = cg_addr_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peri_q <= '1;
      hint_q <= '1;
      jit_q  <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        ADDR_PERI: peri_q <= wdata[N_PERI-1:0];
        ADDR_HINT: hint_q <= wdata[N_TRANS-1:0];
        ADDR_JIT:  jit_q  <= wdata[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      ADDR_PERI: rdata[N_PERI-1:0]  = peri_q;
      ADDR_HINT: rdata[N_TRANS-1:0] = hint_q;
      ADDR_STAT: rdata[N_TRANS-1:0] = status_in;
      ADDR_JIT:  rdata[0]           = jit_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/cg_idle_sync.sv
module cg_idle_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] idle_async,
  output logic [N-1:0] idle_sync
);
  for (genvar g = 0; g < N; g++) begin : g_sync
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= idle_async[g];
        s2 <= s1;
      end
    end
    assign idle_sync[g] = s2;
  end
endmodule

// File: rtl/cg_gate_logic.sv
module cg_gate_logic #(
  parameter int N_PERI  = 4,
  parameter int N_TRANS = 4
) (
  input  logic               scan_on,
  input  logic               glb_en,
  input  logic [N_PERI-1:0]  peri_q,
  input  logic [N_TRANS-1:0] hint_q,
  input  logic [N_TRANS-1:0] idle_sync,
  output logic [N_PERI-1:0]  peri_en,
  output logic [N_TRANS-1:0] trans_en
);
  for (genvar p = 0; p < N_PERI; p++) begin : g_peri
    assign peri_en[p] = scan_on | (glb_en & peri_q[p]);
  end

  for (genvar t = 0; t < N_TRANS; t++) begin : g_trans
    logic want_run;
    assign want_run    = hint_q[t] | ~idle_sync[t];
    assign trans_en[t] = scan_on | (glb_en & want_run);
  end
endmodule

// File: rtl/cg_hint_gate_ctrl.sv
module cg_hint_gate_ctrl #(
  parameter int N_PERI  = 4,
  parameter int N_TRANS = 4,
  parameter int REG_W   = (N_PERI > N_TRANS) ? N_PERI : N_TRANS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               glb_clk_en,
  input  logic [3:0]         scan_mode,
  input  logic [N_TRANS-1:0] unit_idle,
  input  logic               reg_wr_en,
  input  logic [1:0]         reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [N_PERI-1:0]  peri_clk_en,
  output logic [N_TRANS-1:0] trans_clk_en,
  output logic               jitter_en
);
  import cg_pkg::*;

  logic [N_PERI-1:0]  peri_q;
  logic [N_TRANS-1:0] hint_q;
  logic [N_TRANS-1:0] status_q;
  logic [N_TRANS-1:0] idle_s;
  logic [N_TRANS-1:0] trans_int;
  logic               jit_q;
  logic               scan_on;

  assign scan_on = (scan_mode == SCAN_ON);

  cg_reg_bank #(.N_PERI(N_PERI), .N_TRANS(N_TRANS), .REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .status_in(status_q),
    .rdata    (reg_rdata),
    .peri_q   (peri_q),
    .hint_q   (hint_q),
    .jit_q    (jit_q)
  );

  cg_idle_sync #(.N(N_TRANS)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_async(unit_idle),
    .idle_sync (idle_s)
  );

  cg_gate_logic #(.N_PERI(N_PERI), .N_TRANS(N_TRANS)) u_gate (
    .scan_on  (scan_on),
    .glb_en   (glb_clk_en),
    .peri_q   (peri_q),
    .hint_q   (hint_q),
    .idle_sync(idle_s),
    .peri_en  (peri_clk_en),
    .trans_en (trans_int)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '1;
    else        status_q <= trans_int;
  end

  assign trans_clk_en = trans_int;
  assign jitter_en    = jit_q;
endmodule

// File: rtl/cg_hint_gate_chk.sv
module cg_hint_gate_chk #(
  parameter int N_PERI  = 4,
  parameter int N_TRANS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               glb_clk_en,
  input logic [3:0]         scan_mode,
  input logic [N_TRANS-1:0] unit_idle,
  input logic [N_PERI-1:0]  peri_q,
  input logic [N_TRANS-1:0] hint_q,
  input logic [N_TRANS-1:0] status_q,
  input logic [N_PERI-1:0]  peri_clk_en,
  input logic [N_TRANS-1:0] trans_clk_en
);
  import cg_pkg::*;

  p_scan_forces_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode == SCAN_ON) |-> (&peri_clk_en && &trans_clk_en));

  p_global_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_mode != SCAN_ON && !glb_clk_en) |-> (peri_clk_en == '0 && trans_clk_en == '0));

  p_status_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (status_q == $past(trans_clk_en)));

  for (genvar p = 0; p < N_PERI; p++) begin : g_peri_chk
    p_peri_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_mode != SCAN_ON && !peri_q[p]) |-> !peri_clk_en[p]);
  end

  for (genvar t = 0; t < N_TRANS; t++) begin : g_trans_chk
    p_hint_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_clk_en && hint_q[t]) |-> trans_clk_en[t]);

    p_idle_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_mode != SCAN_ON && glb_clk_en && !trans_clk_en[t]) |-> $past(unit_idle[t], 2));

    p_busy_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_clk_en && !$past(unit_idle[t], 2)) |-> trans_clk_en[t]);
  end
endmodule

bind cg_hint_gate_ctrl cg_hint_gate_chk #(.N_PERI(N_PERI), .N_TRANS(N_TRANS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .glb_clk_en  (glb_clk_en),
  .scan_mode   (scan_mode),
  .unit_idle   (unit_idle),
  .peri_q      (peri_q),
  .hint_q      (hint_q),
  .status_q    (status_q),
  .peri_clk_en (peri_clk_en),
  .trans_clk_en(trans_clk_en)
);

// File: tb/sim_cg_hint_gate_ctrl.sv
module sim_cg_hint_gate_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       glb = 1'b1;
  logic [3:0] scan = 4'h0;
  logic [3:0] idle = 4'h0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd2;
  logic [3:0] wdata = 4'h0;
  logic [3:0] rdata, peri_en, trans_en;
  logic       jit;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cg_hint_gate_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .glb_clk_en(glb), .scan_mode(scan),
    .unit_idle(idle), .reg_wr_en(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .peri_clk_en(peri_en), .trans_clk_en(trans_en),
    .jitter_en(jit)
  );

  // Behavioural reference model
  logic [3:0] m_peri, m_hint, m_stat;
  logic       m_jit;
  logic [3:0] idle_hist[$];

  function automatic logic [3:0] seen_idle();
    return (idle_hist.size() >= 2) ? idle_hist[1] : 4'h0;
  endfunction

  function automatic logic [3:0] exp_trans();
    if (scan == 4'hA) return 4'hF;
    if (!glb) return 4'h0;
    return m_hint | ~seen_idle();
  endfunction

  function automatic logic [3:0] exp_peri();
    if (scan == 4'hA) return 4'hF;
    return glb ? m_peri : 4'h0;
  endfunction

  function automatic logic [3:0] exp_rdata();
    case (addr)
      2'd0: return m_peri;
      2'd1: return m_hint;
      2'd2: return m_stat;
      default: return {3'b000, m_jit};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_peri = 4'hF; m_hint = 4'hF; m_stat = 4'hF; m_jit = 1'b0;
      idle_hist.delete();
    end else begin
      m_stat = exp_trans();
      if (we) begin
        case (addr)
          2'd0: m_peri = wdata;
          2'd1: m_hint = wdata;
          2'd3: m_jit  = wdata[0];
          default: ;
        endcase
      end
      idle_hist.push_front(idle);
      if (idle_hist.size() > 2) void'(idle_hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Model comparison on every clock, away from the edge
  always begin
    @(posedge clk);
    #15;
    if (rst_n && !done) begin
      chk("R2 peri_clk_en vs model", peri_en, exp_peri());
      chk("R5 trans_clk_en vs model", trans_en, exp_trans());
      chk("R10 jitter_en vs model", {3'b000, jit}, {3'b000, m_jit});
      chk("R11 reg_rdata vs model", rdata, exp_rdata());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic report();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset peri", peri_en, 4'hF);
    chk("R1 reset trans", trans_en, 4'hF);
    chk("R1 reset jitter", {3'b000, jit}, 4'h0);
    chk("R1 reset status", rdata, 4'hF);

    wr(2'd1, 4'h0);
    chk("R6 busy units keep running", trans_en, 4'hF);
    repeat (3) @(negedge clk);
    #1;
    chk("R6 busy units still running", trans_en, 4'hF);

    addr = 2'd2;
    idle = 4'hF;
    @(negedge clk); #1;
    chk("R5 one edge after idle", trans_en, 4'hF);
    @(negedge clk); #1;
    chk("R5 two edges after idle", trans_en, 4'h0);
    chk("R8 status lags gate", rdata, 4'hF);
    @(negedge clk); #1;
    chk("R8 status follows gate", rdata, 4'h0);

    wr(2'd1, 4'h3);
    chk("R4 hint set runs clock", trans_en, 4'h3);
    addr = 2'd2;
    @(negedge clk); #1;
    chk("R8 status equals hint when idle", rdata, 4'h3);

    wr(2'd2, 4'hC);
    chk("R9 status write ignored", rdata, 4'h3);
    addr = 2'd1; #1;
    chk("R9 hints untouched by status write", rdata, 4'h3);

    wr(2'd0, 4'h5);
    chk("R2 peri enables follow bits", peri_en, 4'h5);
    glb = 1'b0; #1;
    chk("R7 global off peri", peri_en, 4'h0);
    chk("R7 global off trans", trans_en, 4'h0);
    scan = 4'hA; #1;
    chk("R3 scan forces peri", peri_en, 4'hF);
    chk("R3 scan forces trans", trans_en, 4'hF);
    scan = 4'hB; #1;
    chk("R3 non-true scan pattern inactive", peri_en, 4'h0);
    scan = 4'h0; glb = 1'b1;

    wr(2'd3, 4'h1);
    chk("R10 jitter set", {3'b000, jit}, 4'h1);
    chk("R11 read jitter", rdata, 4'h1);
    wr(2'd3, 4'h0);
    chk("R10 jitter clear", {3'b000, jit}, 4'h0);

    wr(2'd1, 4'hF);
    chk("R4 all hints set", trans_en, 4'hF);
    addr = 2'd2;
    @(negedge clk); #1;
    chk("R8 all-ones hints give all-ones status", rdata, 4'hF);

    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      idle = 4'($urandom);
      glb  = ($urandom % 8) != 0;
      case ($urandom % 8)
        0: scan = 4'hA;
        1: scan = 4'($urandom);
        default: scan = 4'h0;
      endcase
      we    = ($urandom % 4) == 0;
      addr  = 2'($urandom);
      wdata = 4'($urandom);
    end
    @(negedge clk);
    we = 1'b0;
    repeat (2) @(negedge clk);
    report();
  end
endmodule